// File: doc/BRIEF.md
# Multi-Block Flash Erase Sequencer

This controller erases a chosen group of flash blocks and then checks that every byte of each block reads back as erased. Software or a higher-level engine presents a block-select mask and a one-cycle start request. The sequencer then runs a series of attempts. Each attempt holds the array's erase enable for a pulse whose length doubles over the first four attempts and then stays fixed. It raises a watchdog enable for exactly the length of that pulse.

After each pulse the block switches the array into verify mode and waits a settling time. It then visits the selected blocks in ascending index order. At each address it issues a one-cycle dummy write of 0xFF so that the array captures the address, waits a hold time and then compares the returned byte against 0xFF. A block whose every byte matches is dropped from the pending mask. A block that mismatches stops its walk at the first bad byte and stays pending. When the pass is over, the sequencer either reports completion (no pending blocks), starts another attempt with only the pending blocks, or stops with an error once the attempt limit is reached.

All durations are clock-cycle counts and the block layout is a base address plus a fixed block size, so short values can stand in for real timings.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset and whenever not busy (idle or error state), the erase enable, verify enable, write strobe and watchdog enable are all low; done, error and the pending mask reset to zero.
- R2: A start request while idle or in error with a nonzero mask raises busy and the erase enable on the next cycle and clears done and error; a start request while busy has no effect on any output.
- R3: Attempt n holds the erase enable for ERASE0_CYC × 2^(n−1) consecutive cycles for n ≤ 4, and for ERASE0_CYC × 8 cycles on every later attempt.
- R4: The watchdog enable is high in exactly the cycles in which the erase enable is high.
- R5: After each erase pulse the verify enable rises at once and stays high for VS1_CYC cycles before the first dummy write of that pass.
- R6: Each verified address gets a single-cycle write strobe carrying data 0xFF, then VS2_CYC cycles with the address held, then one read cycle in which the returned byte is compared with 0xFF.
- R7: Block b spans addresses BLK_BASE + b×BLK_SIZE up to BLK_BASE + (b+1)×BLK_SIZE − 1 and is walked from its lowest address upward. Blocks are visited in ascending index order, one cycle per block index, and blocks not pending are skipped.
- R8: A block whose every byte reads 0xFF has its pending bit cleared in the cycle after its last read. A mismatch ends that block's walk at once and leaves its bit set. Pending bits are never set while busy.
- R9: When the verify pass is over, verify drops for one cycle with busy still high. If nothing is pending, busy falls and done rises on the next cycle.
- R10: If blocks are still pending after attempt MAX_TRY, the block enters the error state (error high, busy low) and the pending mask shows the failing blocks; a later accepted start leaves the error state.
- R11: A start with an all-zero mask produces no pulse: done rises on the next cycle and busy stays low.
- R12: The erase enable and the verify enable are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin an erase run |
| blk_mask_i | input | NUM_BLK | Blocks to erase, sampled with start_i |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Last run finished with every block erased |
| err_o | output | 1 | Attempt limit reached with blocks still pending |
| pend_o | output | NUM_BLK | Blocks not yet verified as erased |
| wdt_en_o | output | 1 | Watchdog enable, high during each erase pulse |
| fl_erase_o | output | 1 | Array erase-mode enable |
| fl_verify_o | output | 1 | Array erase-verify mode enable |
| fl_addr_o | output | ADDR_W | Array address |
| fl_wr_o | output | 1 | Dummy-write strobe that latches the address |
| fl_wdata_o | output | 8 | Write data, 0xFF during the strobe |
| fl_rdata_i | input | 8 | Byte returned by the array |

## Verification
The bench builds three blocks of four bytes each starting at 0x10, a two-cycle first pulse, three and two cycles of verify settling and a limit of six attempts. With these values a block that needs many pulses drives the run through the doubling phase into the fixed 16-cycle pulses and on to the error exit, in a few hundred cycles. The bench's array model keeps a bad byte in each block for a chosen number of pulses, placed at the last, second and first address respectively. This covers mismatches at the end, the middle and the start of a walk, as well as blocks that pass on different attempts.

// File: rtl/fes_pkg.sv
// Shared definitions for the flash erase sequencer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package fes_pkg;

    // Controller states; ST_IDLE and ST_ERR are the only non-busy states.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ERASE,
        ST_SETTLE,
        ST_SCAN,
        ST_WRITE,
        ST_HOLD,
        ST_READ,
        ST_CLOSE,
        ST_ERR
    } fes_state_e;

    // Value an erased byte reads back as, also the dummy-write data.
    localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/fes_pulse_sched.sv
// Erase pulse length schedule.
// Turns an attempt number (1-based) into a pulse length in cycles:
// the base length doubles for attempts 1..4 and then stays at 8x.
// Assumes try_i >= 1 whenever the result is used.
module fes_pulse_sched #(
    parameter int ERASE0_CYC = 2,
    parameter int TRY_W      = 4,
    parameter int LEN_W      = 5
) (
    input  logic [TRY_W-1:0] try_i,
    output logic [LEN_W-1:0] len_o
);

    localparam int MAX_SHIFT = 3;

    logic [1:0] shift;

    // Choose the doubling count, saturating after the fourth attempt.
    always_comb begin
        if (try_i >= TRY_W'(MAX_SHIFT + 1)) begin
            shift = 2'(MAX_SHIFT);
        end else if (try_i == '0) begin
            shift = 2'd0;
        end else begin
            shift = 2'(try_i - 1'b1);
        end
        len_o = LEN_W'(ERASE0_CYC) << shift;
    end

    // R3: the pulse stays between the base length and eight times it.
    always_comb begin
        if (try_i != '0) begin
            p_len_range_r3: assert (len_o >= LEN_W'(ERASE0_CYC) && len_o <= LEN_W'(ERASE0_CYC * 8));
        end
    end

endmodule

// File: rtl/fes_dwell_timer.sv
// Down-counting dwell timer.
// Load with (cycles - 1); zero_o is high in the last cycle of the dwell.
// Holds at zero until the next load.
module fes_dwell_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R3: the count never wraps past zero.
    p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && $past(cnt_q) == '0 && $past(!load_i)) |-> cnt_q == '0);

endmodule

// File: rtl/flash_erase_seq.sv
// Multi-block flash erase sequencer (top).
// Runs erase pulses of growing length over the pending blocks, verifies
// each pending block byte by byte (dummy write, hold, read) and drops
// blocks that read fully erased. Stops when nothing is pending or after
// MAX_TRY attempts. The array port is assumed to return read data
// combinationally for the address presented. Durations must be >= 1.
module flash_erase_seq #(
    parameter int NUM_BLK    = 4,
    parameter int ADDR_W     = 12,
    parameter int BLK_BASE   = 0,
    parameter int BLK_SIZE   = 1024,
    parameter int ERASE0_CYC = 50000,
    parameter int VS1_CYC    = 32,
    parameter int VS2_CYC    = 16,
    parameter int MAX_TRY    = 602
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [NUM_BLK-1:0] blk_mask_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o,
    output logic [NUM_BLK-1:0] pend_o,
    output logic               wdt_en_o,
    output logic               fl_erase_o,
    output logic               fl_verify_o,
    output logic [ADDR_W-1:0]  fl_addr_o,
    output logic               fl_wr_o,
    output logic [7:0]         fl_wdata_o,
    input  logic [7:0]         fl_rdata_i
);

    import fes_pkg::*;

    localparam int BLK_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;
    localparam int TRY_RAW = $clog2(MAX_TRY + 1);
    localparam int TRY_W   = (TRY_RAW < 3) ? 3 : TRY_RAW;
    localparam int LONGEST = ERASE0_CYC * 8;
    localparam int LEN_W   = $clog2(LONGEST + 1);
    localparam int MAX_C0  = (LONGEST > VS1_CYC) ? LONGEST : VS1_CYC;
    localparam int MAX_CNT = (MAX_C0 > VS2_CYC) ? MAX_C0 : VS2_CYC;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    fes_state_e         st_q;
    logic [NUM_BLK-1:0] pend_q;
    logic [BLK_W-1:0]   blk_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [TRY_W-1:0]   try_q;
    logic               done_q;

    logic [ADDR_W-1:0]  base_tab [NUM_BLK];
    logic [ADDR_W-1:0]  top_tab  [NUM_BLK];

    logic               start_ok;
    logic               blk_last;
    logic               rd_ok;
    logic               at_top;
    logic               retry;
    logic [TRY_W-1:0]   sched_try;
    logic [LEN_W-1:0]   pulse_len;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_zero;

    // Per-block address bounds derived from base and size.
    for (genvar g = 0; g < NUM_BLK; g++) begin : g_bounds
        assign base_tab[g] = ADDR_W'(BLK_BASE + g * BLK_SIZE);
        assign top_tab[g]  = ADDR_W'(BLK_BASE + (g + 1) * BLK_SIZE - 1);
    end

    assign start_ok = start_i && (st_q == ST_IDLE || st_q == ST_ERR);
    assign blk_last = (blk_q == BLK_W'(NUM_BLK - 1));
    assign rd_ok    = (fl_rdata_i == ERASED_BYTE);
    assign at_top   = (addr_q == top_tab[blk_q]);
    assign retry    = (st_q == ST_CLOSE) && (pend_q != '0) && (try_q < TRY_W'(MAX_TRY));

    // Attempt number for the pulse about to be loaded.
    assign sched_try = (st_q == ST_CLOSE) ? try_q + 1'b1 : TRY_W'(1);

    fes_pulse_sched #(
        .ERASE0_CYC (ERASE0_CYC),
        .TRY_W      (TRY_W),
        .LEN_W      (LEN_W)
    ) u_sched (
        .try_i (sched_try),
        .len_o (pulse_len)
    );

    // Pick the dwell to start on each timed state entry.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (start_ok && blk_mask_i != '0) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(pulse_len - 1'b1);
        end else if (st_q == ST_ERASE && tmr_zero) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(VS1_CYC - 1);
        end else if (st_q == ST_WRITE) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(VS2_CYC - 1);
        end else if (retry) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(pulse_len - 1'b1);
        end
    end

    fes_dwell_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    // Main sequencing: erase, settle, per-block walk, decide.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            pend_q <= '0;
            blk_q  <= '0;
            addr_q <= '0;
            try_q  <= '0;
            done_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE, ST_ERR: begin
                    if (start_i) begin
                        pend_q <= blk_mask_i;
                        if (blk_mask_i == '0) begin
                            done_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else begin
                            done_q <= 1'b0;
                            try_q  <= TRY_W'(1);
                            st_q   <= ST_ERASE;
                        end
                    end
                end
                ST_ERASE: begin
                    if (tmr_zero) st_q <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (tmr_zero) begin
                        blk_q <= '0;
                        st_q  <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (pend_q[blk_q]) begin
                        addr_q <= base_tab[blk_q];
                        st_q   <= ST_WRITE;
                    end else if (blk_last) begin
                        st_q <= ST_CLOSE;
                    end else begin
                        blk_q <= blk_q + 1'b1;
                    end
                end
                ST_WRITE: begin
                    st_q <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (tmr_zero) st_q <= ST_READ;
                end
                ST_READ: begin
                    if (rd_ok && !at_top) begin
                        addr_q <= addr_q + 1'b1;
                        st_q   <= ST_WRITE;
                    end else begin
                        if (rd_ok) pend_q[blk_q] <= 1'b0;
                        if (blk_last) begin
                            st_q <= ST_CLOSE;
                        end else begin
                            blk_q <= blk_q + 1'b1;
                            st_q  <= ST_SCAN;
                        end
                    end
                end
                ST_CLOSE: begin
                    if (pend_q == '0) begin
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end else if (retry) begin
                        try_q <= try_q + 1'b1;
                        st_q  <= ST_ERASE;
                    end else begin
                        st_q <= ST_ERR;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Moore decode of the array and status outputs.
    always_comb begin
        busy_o      = (st_q != ST_IDLE) && (st_q != ST_ERR);
        err_o       = (st_q == ST_ERR);
        done_o      = done_q;
        pend_o      = pend_q;
        fl_erase_o  = (st_q == ST_ERASE);
        wdt_en_o    = (st_q == ST_ERASE);
        fl_verify_o = (st_q == ST_SETTLE) || (st_q == ST_SCAN) || (st_q == ST_WRITE)
                   || (st_q == ST_HOLD)   || (st_q == ST_READ);
        fl_wr_o     = (st_q == ST_WRITE);
        fl_wdata_o  = fl_wr_o ? ERASED_BYTE : 8'h00;
        fl_addr_o   = addr_q;
    end

    // R12: never erase and verify at once.
    p_mode_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_erase_o && fl_verify_o));

    // R1: outside a run every array control is low.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(fl_erase_o || fl_verify_o || fl_wr_o || wdt_en_o));

    // R4: watchdog follows the erase pulse.
    p_wdt_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_en_o == fl_erase_o);

    // R6: the dummy write is a single-cycle strobe.
    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fl_wr_o |=> !fl_wr_o);

    // R6: the latched address is held after the strobe.
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fl_wr_o |=> $stable(fl_addr_o));

    // R8: pending bits only ever clear during a run.
    p_pend_no_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ((pend_o & ~$past(pend_o)) == '0));

    // R10: the attempt counter stays within the limit.
    p_try_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        try_q <= TRY_W'(MAX_TRY));

endmodule

// File: tb/flash_erase_seq_tb.sv
// Bench: behavioural array model plus a trace-based reference model.
// On each accepted start the model computes the expected per-cycle
// output trace into a queue; every falling edge pops and compares.
module flash_erase_seq_tb_top;

    localparam int NB   = 3;
    localparam int AW   = 8;
    localparam int BASE = 16;
    localparam int BS   = 4;
    localparam int E0   = 2;
    localparam int VS1  = 3;
    localparam int VS2  = 2;
    localparam int MAXT = 6;

    typedef struct packed {
        logic          busy;
        logic          done;
        logic          err;
        logic          ers;
        logic          ver;
        logic          wr;
        logic          achk;
        logic [AW-1:0] addr;
        logic [NB-1:0] pend;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [NB-1:0] blk_mask_i = '0;
    logic          busy_o, done_o, err_o, wdt_en_o, fl_erase_o, fl_verify_o, fl_wr_o;
    logic [NB-1:0] pend_o;
    logic [AW-1:0] fl_addr_o;
    logic [7:0]    fl_wdata_o;
    logic [7:0]    fl_rdata_i;

    int   n_chk = 0;
    int   n_fail = 0;
    int   need_dut [NB];
    int   need_mdl [NB];
    exp_t exp_q [$];
    int   plen_q [$];
    int   plen_run = 0;
    logic idle_done = 1'b0;
    logic idle_err = 1'b0;
    logic [NB-1:0] idle_pend = '0;
    logic req_go = 1'b0;
    logic [NB-1:0] req_mask = '0;
    logic compare_on = 1'b0;
    logic finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    flash_erase_seq #(
        .NUM_BLK (NB), .ADDR_W (AW), .BLK_BASE (BASE), .BLK_SIZE (BS),
        .ERASE0_CYC (E0), .VS1_CYC (VS1), .VS2_CYC (VS2), .MAX_TRY (MAXT)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .blk_mask_i (blk_mask_i),
        .busy_o (busy_o), .done_o (done_o), .err_o (err_o), .pend_o (pend_o),
        .wdt_en_o (wdt_en_o), .fl_erase_o (fl_erase_o), .fl_verify_o (fl_verify_o),
        .fl_addr_o (fl_addr_o), .fl_wr_o (fl_wr_o), .fl_wdata_o (fl_wdata_o),
        .fl_rdata_i (fl_rdata_i)
    );

    // Bad byte position per block: last, second, first address.
    function automatic int bad_addr(input int b);
        if (b == 0) return BASE + BS - 1;
        if (b == 1) return BASE + BS + 1;
        return BASE + 2 * BS;
    endfunction

    // Array model: a block reads a bad byte until its pulse budget runs out.
    always_comb begin
        fl_rdata_i = 8'hFF;
        for (int b = 0; b < NB; b++) begin
            if (need_dut[b] > 0 && int'(fl_addr_o) == bad_addr(b)) fl_rdata_i = 8'h00;
        end
    end

    always @(negedge fl_erase_o) begin
        for (int b = 0; b < NB; b++) if (need_dut[b] > 0) need_dut[b]--;
    end

    function automatic exp_t mk(input logic bz, dn, er, es, vr, w, ac,
                                input int ad, input logic [NB-1:0] pd);
        exp_t e;
        e.busy = bz; e.done = dn; e.err = er; e.ers = es; e.ver = vr;
        e.wr = w; e.achk = ac; e.addr = AW'(ad); e.pend = pd;
        return e;
    endfunction

    // Expected trace from the requirements (R2..R11).
    task automatic build(input logic [NB-1:0] m);
        int nd [NB];
        logic [NB-1:0] p;
        int t;
        int len;
        int ad;
        p = m;
        t = 1;
        for (int b = 0; b < NB; b++) nd[b] = need_mdl[b];
        if (m == '0) begin
            exp_q.push_back(mk(0, 1, 0, 0, 0, 0, 0, 0, '0));   // R11
            return;
        end
        forever begin
            len = E0 << ((t > 4) ? 3 : t - 1);                // R3
            repeat (len) exp_q.push_back(mk(1, 0, 0, 1, 0, 0, 0, 0, p));
            for (int b = 0; b < NB; b++) if (nd[b] > 0) nd[b]--;
            repeat (VS1) exp_q.push_back(mk(1, 0, 0, 0, 1, 0, 0, 0, p));   // R5
            for (int b = 0; b < NB; b++) begin
                exp_q.push_back(mk(1, 0, 0, 0, 1, 0, 0, 0, p));            // R7 scan
                if (p[b]) begin
                    for (int a = 0; a < BS; a++) begin
                        ad = BASE + b * BS + a;
                        exp_q.push_back(mk(1, 0, 0, 0, 1, 1, 1, ad, p));   // R6
                        repeat (VS2) exp_q.push_back(mk(1, 0, 0, 0, 1, 0, 1, ad, p));
                        exp_q.push_back(mk(1, 0, 0, 0, 1, 0, 1, ad, p));
                        if (nd[b] > 0 && ad == bad_addr(b)) break;         // R8
                        if (a == BS - 1) p[b] = 1'b0;
                    end
                end
            end
            exp_q.push_back(mk(1, 0, 0, 0, 0, 0, 0, 0, p));                // R9 close
            if (p == '0) begin
                exp_q.push_back(mk(0, 1, 0, 0, 0, 0, 0, 0, p));
                return;
            end
            if (t == MAXT) begin
                exp_q.push_back(mk(0, 0, 1, 0, 0, 0, 0, 0, p));            // R10
                return;
            end
            t++;
        end
    endtask

    task automatic fail_line(input string req, input string what, input int act, input int expv);
        $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, expv, $time);
    endtask

    // Per-cycle comparison, pulse-length monitor and start driver.
    always @(negedge clk) begin
        exp_t e;
        logic bad;
        if (compare_on && !finished) begin
            if (fl_erase_o) plen_run++;
            else if (plen_run > 0) begin plen_q.push_back(plen_run); plen_run = 0; end
            if (exp_q.size() > 0) e = exp_q.pop_front();
            else e = mk(0, idle_done, idle_err, 0, 0, 0, 0, 0, idle_pend);
            if (!e.busy) begin idle_done = e.done; idle_err = e.err; idle_pend = e.pend; end
            bad = 1'b0;
            n_chk++;
            if (busy_o !== e.busy)     begin bad = 1; fail_line("R2", "busy", busy_o, e.busy); end
            if (fl_erase_o !== e.ers)  begin bad = 1; fail_line("R3", "erase", fl_erase_o, e.ers); end
            if (wdt_en_o !== e.ers)    begin bad = 1; fail_line("R4", "wdt", wdt_en_o, e.ers); end
            if (fl_verify_o !== e.ver) begin bad = 1; fail_line("R5", "verify", fl_verify_o, e.ver); end
            if (fl_wr_o !== e.wr)      begin bad = 1; fail_line("R6", "wr", fl_wr_o, e.wr); end
            if (e.wr && fl_wdata_o !== 8'hFF) begin bad = 1; fail_line("R6", "wdata", fl_wdata_o, 8'hFF); end
            if (e.achk && fl_addr_o !== e.addr) begin bad = 1; fail_line("R7", "addr", fl_addr_o, e.addr); end
            if (pend_o !== e.pend)     begin bad = 1; fail_line("R8", "pend", pend_o, e.pend); end
            if (done_o !== e.done)     begin bad = 1; fail_line("R9", "done", done_o, e.done); end
            if (err_o !== e.err)       begin bad = 1; fail_line("R10", "err", err_o, e.err); end
            if (fl_erase_o && fl_verify_o) begin bad = 1; fail_line("R12", "erase&verify", 1, 0); end
            if (bad) n_fail++;
            start_i = 1'b0;
            if (req_go) begin
                start_i = 1'b1;
                blk_mask_i = req_mask;
                if (exp_q.size() == 0) build(req_mask);
                req_go = 1'b0;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int expv);
        n_chk++;
        if (act != expv) begin n_fail++; fail_line(req, what, act, expv); end
    endtask

    task automatic set_need(input int n0, input int n1, input int n2);
        need_dut[0] = n0; need_dut[1] = n1; need_dut[2] = n2;
        need_mdl[0] = n0; need_mdl[1] = n1; need_mdl[2] = n2;
    endtask

    task automatic kick(input logic [NB-1:0] m);
        req_mask = m;
        req_go = 1'b1;
        wait (req_go == 1'b0);
    endtask

    task automatic drain;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_pulses(input int n, input string tag);
        check("R3", {tag, " pulse count"}, plen_q.size(), n);
        for (int i = 0; i < plen_q.size() && i < n; i++) begin
            check("R3", {tag, " pulse length"}, plen_q[i], E0 << ((i >= 3) ? 3 : i));
        end
        plen_q.delete();
    endtask

    task automatic summary;
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        set_need(0, 0, 0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check("R1", "busy", busy_o, 0);
        check("R1", "done", done_o, 0);
        check("R1", "err", err_o, 0);
        check("R1", "pend", pend_o, 0);
        check("R1", "controls", {fl_erase_o, fl_verify_o, fl_wr_o, wdt_en_o}, 0);
        compare_on = 1'b1;
        @(negedge clk);

        // R2 R9: two blocks pass after the first pulse.
        set_need(1, 0, 1);
        kick(3'b101);
        drain();
        check("R9", "done after clean pass", done_o, 1);
        check_pulses(1, "single");

        // R8 R3: blocks pass on different attempts; R2 start while busy ignored.
        set_need(3, 1, 2);
        kick(3'b111);
        repeat (5) @(negedge clk);
        kick(3'b010);
        drain();
        check("R8", "pend cleared", pend_o, 0);
        check("R9", "done after retries", done_o, 1);
        check_pulses(3, "staggered");

        // R11: empty mask.
        kick(3'b000);
        drain();
        check("R11", "done on empty mask", done_o, 1);
        check("R11", "no pulse", plen_q.size(), 0);

        // R10 R3: one block never erases; limit reached, pulse length saturates.
        set_need(0, 100, 0);
        kick(3'b011);
        drain();
        check("R10", "err", err_o, 1);
        check("R10", "failing block", pend_o, 3'b010);
        check("R10", "busy low in error", busy_o, 0);
        check_pulses(MAXT, "limit");

        // R10 R2: restart from the error state.
        set_need(0, 0, 0);
        kick(3'b001);
        drain();
        check("R10", "err cleared", err_o, 0);
        check("R2", "done after restart", done_o, 1);
        plen_q.delete();

        summary();
    end

endmodule